// File: doc/BRIEF.md
# Protection shutdown supervisor

This block decides which supply and drive permits stay on after a fault. It gathers flags from three converter channels (under-voltage, over-voltage and over-current for each), from a regulator channel, from motor over-current and from thermal shutdown. Each flag is captured into a sticky latch. A small supervisor state machine turns the captured faults into four outputs. `conv_on`, `reg_on` and `motor_on` permit the converters, the regulator and the motor bridges. `rst_out_n` is an active-low reset-out that can be held low, held high or pulsed low for a fixed number of clocks.

The reaction to a thermal or motor over-current fault is chosen by configuration. That choice is captured when the fault latches, so changing the configuration later does not change a fault that is already held. Two kinds of release exist. A hard release (`supply_low` high or `ext_rst_n` low) clears every latch. A soft release (a low-to-high step of `sleep_n`) clears only the faults whose mode allows it. A 4-bit select routes one status item onto `logic_out`: a latched fault indication (active low), a revision or device-code bit, or a constant high.

The supervisor has five states:
- SV_RUN: everything permitted, reset-out high.
- SV_CONV_OFF: converters and motors off, regulator on, reset-out low.
- SV_HARD_OFF: everything off, reset-out low.
- SV_SOFT_PULSE: motors off, converters and regulator on, reset-out low.
- SV_SOFT_HOLD: motors off, converters and regulator on, reset-out high.

The transitions are evaluated in priority order:
- Any latched converter fault leads from any state to SV_CONV_OFF.
- Otherwise, a latched fault of hard mode leads to SV_HARD_OFF.
- Otherwise, a soft-mode fault leads to SV_SOFT_PULSE when a pulse is wanted and the state is not already soft, or to SV_SOFT_HOLD when it is not.
- SV_SOFT_PULSE moves to SV_SOFT_HOLD after `PULSE_LEN` cycles.
- SV_SOFT_HOLD stays put while its faults remain.
- With no latched fault, any state returns to SV_RUN.

Top module: `prot_supervisor`

## Requirements
- R1: Any converter flag (`conv_uv`, `conv_ov` or `conv_oc`, any channel) gives `conv_on`=0, `motor_on`=0, `reg_on`=1 and `rst_out_n`=0. These hold until a hard release, and a rising edge of `sleep_n` does not clear them.
- R2: A thermal fault latched with `tsd_mode` 2'b00 or 2'b11 gives all permits 0 and `rst_out_n`=0. A rising edge of `sleep_n` does not clear it.
- R3: A thermal fault latched with `tsd_mode` 2'b01 gives `motor_on`=0, `conv_on`=1, `reg_on`=1 and `rst_out_n`=1. A rising edge of `sleep_n` clears it.
- R4: A thermal fault latched with `tsd_mode` 2'b10 behaves as in R3, except that `rst_out_n` is first low for exactly `PULSE_LEN` cycles and then returns high.
- R5: A motor over-current latched with `misd_mode`=0 turns the motors off and keeps the converters and regulator on. `rst_out_n` is pulsed as in R4, and a rising edge of `sleep_n` clears the fault.
- R6: A motor over-current latched with `misd_mode`=1 gives all permits 0 and `rst_out_n`=0. Only a hard release clears it.
- R7: `supply_low`=1 or `ext_rst_n`=0 sampled on a clock clears every latch. The outputs return to the run values one clock later.
- R8: A flag high on one clock edge is latched at that edge, and the outputs change at the next edge. The mode is taken from the configuration at the latching edge, and later configuration changes do not affect a held fault.
- R9: Priority is converter fault over hard-mode fault over soft-mode fault.
- R10: `logic_out` for `sel` 0,1,2 is low while converter A,B,C (bit 0,1,2) has any latched fault. It is also low while the matching fault is latched for: 3 = regulator over-current, 4 = any converter under-voltage, 5 = any converter over-voltage, 6 = motor over-current, 7 = thermal, 14 = regulator-channel fault. It is high otherwise.
- R11: `logic_out` for `sel` 8,9,10 is `REV_CODE` bit 0,1,2, and for 11,12 it is `DEV_CODE` bit 0,1. `sel` 13 and 15 give a constant 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low block reset |
| ext_rst_n | input | 1 | reset input, low is a hard release |
| supply_low | input | 1 | supply-low flag, high is a hard release |
| sleep_n | input | 1 | sleep line, its rising edge is a soft release |
| conv_uv | input | 3 | converter under-voltage flags, bit n = channel n |
| conv_ov | input | 3 | converter over-voltage flags |
| conv_oc | input | 3 | converter over-current flags |
| reg_oc | input | 1 | regulator over-current flag |
| reg_fault | input | 1 | regulator-channel fault flag |
| motor_oc | input | 1 | motor over-current flag |
| thermal | input | 1 | thermal shutdown flag |
| tsd_mode | input | 2 | thermal reaction mode |
| misd_mode | input | 1 | motor over-current reaction mode |
| sel | input | 4 | logic-out select |
| conv_on | output | 1 | converter permit |
| reg_on | output | 1 | regulator permit |
| motor_on | output | 1 | motor bridge permit |
| rst_out_n | output | 1 | active-low reset-out |
| logic_out | output | 1 | selected status bit |

## Verification
The assertions assume that every flag and configuration input is synchronous to `clk`, with no settling within the cycle. They also assume that `sleep_n` starts high after block reset, so that the first rising edge is a true low-to-high step. The stimulus drives all inputs on the falling edge and holds `sleep_n` high except for deliberate one-cycle low steps. It raises each flag for a single cycle, so that every later output value comes from the latches alone. A behavioural model in the bench predicts every output on every clock, including the cycles inside the reset-out pulse and the cycle on which a release and a fresh flag coincide.

// File: rtl/prot_sup_pkg.sv
package prot_sup_pkg;

    localparam int NUM_CONV = 3;

    typedef enum logic [2:0] {
        SV_RUN        = 3'd0,
        SV_CONV_OFF   = 3'd1,
        SV_HARD_OFF   = 3'd2,
        SV_SOFT_PULSE = 3'd3,
        SV_SOFT_HOLD  = 3'd4
    } sv_state_e;

    typedef struct packed {
        logic conv_any;
        logic hard_any;
        logic soft_any;
        logic pulse_want;
    } fault_summary_t;

    localparam logic [1:0] TSD_OFF_A   = 2'b00;
    localparam logic [1:0] TSD_SOFT    = 2'b01;
    localparam logic [1:0] TSD_PULSE   = 2'b10;
    localparam logic [1:0] TSD_OFF_B   = 2'b11;

endpackage

// File: rtl/fault_latch_bank.sv
module fault_latch_bank
    import prot_sup_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_rst_n,
    input  logic                supply_low,
    input  logic                sleep_n,
    input  logic [NUM_CONV-1:0] conv_uv,
    input  logic [NUM_CONV-1:0] conv_ov,
    input  logic [NUM_CONV-1:0] conv_oc,
    input  logic                reg_oc,
    input  logic                reg_fault,
    input  logic                motor_oc,
    input  logic                thermal,
    input  logic [1:0]          tsd_mode,
    input  logic                misd_mode,
    output logic [NUM_CONV-1:0] uv_q,
    output logic [NUM_CONV-1:0] ov_q,
    output logic [NUM_CONV-1:0] oc_q,
    output logic                reg_oc_q,
    output logic                reg_any_q,
    output logic                mot_q,
    output logic                tsd_q,
    output fault_summary_t      summ
);

    logic hard_clr;
    logic soft_clr;
    logic sleep_q;
    logic mot_hard_q;
    logic tsd_hard_q;
    logic tsd_pulse_q;

    assign hard_clr = supply_low | ~ext_rst_n;
    assign soft_clr = sleep_n & ~sleep_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sleep_q <= 1'b1;
        else        sleep_q <= sleep_n;
    end

    // one sticky trio per converter channel
    for (genvar ch = 0; ch < NUM_CONV; ch++) begin : g_chan
        logic [2:0] trio_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        trio_q <= '0;
            else if (hard_clr) trio_q <= '0;
            else               trio_q <= trio_q | {conv_oc[ch], conv_ov[ch], conv_uv[ch]};
        end
        assign uv_q[ch] = trio_q[0];
        assign ov_q[ch] = trio_q[1];
        assign oc_q[ch] = trio_q[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_oc_q  <= 1'b0;
            reg_any_q <= 1'b0;
        end else if (hard_clr) begin
            reg_oc_q  <= 1'b0;
            reg_any_q <= 1'b0;
        end else begin
            reg_oc_q  <= reg_oc_q | reg_oc;
            reg_any_q <= reg_any_q | reg_fault;
        end
    end

    // motor over-current: reaction captured when the latch sets
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mot_q      <= 1'b0;
            mot_hard_q <= 1'b0;
        end else if (hard_clr) begin
            mot_q      <= 1'b0;
            mot_hard_q <= 1'b0;
        end else if (mot_q && soft_clr && !mot_hard_q) begin
            mot_q      <= 1'b0;
        end else if (!mot_q && motor_oc) begin
            mot_q      <= 1'b1;
            mot_hard_q <= misd_mode;
        end
    end

    // thermal: reaction captured when the latch sets
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tsd_q       <= 1'b0;
            tsd_hard_q  <= 1'b0;
            tsd_pulse_q <= 1'b0;
        end else if (hard_clr) begin
            tsd_q       <= 1'b0;
            tsd_hard_q  <= 1'b0;
            tsd_pulse_q <= 1'b0;
        end else if (tsd_q && soft_clr && !tsd_hard_q) begin
            tsd_q       <= 1'b0;
        end else if (!tsd_q && thermal) begin
            tsd_q       <= 1'b1;
            tsd_hard_q  <= (tsd_mode == TSD_OFF_A) || (tsd_mode == TSD_OFF_B);
            tsd_pulse_q <= (tsd_mode == TSD_PULSE);
        end
    end

    always_comb begin
        summ.conv_any   = |(uv_q | ov_q | oc_q);
        summ.hard_any   = (mot_q & mot_hard_q) | (tsd_q & tsd_hard_q);
        summ.soft_any   = (mot_q & ~mot_hard_q) | (tsd_q & ~tsd_hard_q);
        summ.pulse_want = (mot_q & ~mot_hard_q) | (tsd_q & tsd_pulse_q);
    end

    // R7: a hard release empties every fault latch on the next edge
    assert_hard_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hard_clr |=> (uv_q == '0) && (ov_q == '0) && (oc_q == '0) && !mot_q && !tsd_q)
        else $error("hard release left a latch set");

    // R2: a hard-mode thermal latch survives everything but a hard release
    assert_tsd_hard_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tsd_q && tsd_hard_q && !hard_clr) |=> tsd_q)
        else $error("hard thermal latch dropped");

    // R8: a motor flag is held from the edge that sees it
    assert_motor_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (motor_oc && !hard_clr && !(mot_q && soft_clr && !mot_hard_q)) |=> mot_q)
        else $error("motor flag not latched");

endmodule

// File: rtl/rst_pulse_timer.sv
module rst_pulse_timer #(
    parameter int PULSE_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int CW = $clog2(PULSE_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(PULSE_LEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + 1'b1;
        else          cnt_q <= '0;
    end

    assign done = run && (cnt_q == LAST);

    // R4: the low phase never outlasts its programmed length
    assert_pulse_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= LAST))
        else $error("reset-out pulse overran");

endmodule

// File: rtl/status_select.sv
module status_select
    import prot_sup_pkg::*;
#(
    parameter logic [2:0] REV_CODE = 3'b010,
    parameter logic [1:0] DEV_CODE = 2'b01
) (
    input  logic [3:0]          sel,
    input  logic [NUM_CONV-1:0] uv_q,
    input  logic [NUM_CONV-1:0] ov_q,
    input  logic [NUM_CONV-1:0] oc_q,
    input  logic                reg_oc_q,
    input  logic                reg_any_q,
    input  logic                mot_q,
    input  logic                tsd_q,
    output logic                logic_out
);

    logic [NUM_CONV-1:0] chan_bad;
    assign chan_bad = uv_q | ov_q | oc_q;

    always_comb begin
        logic_out = 1'b1;
        unique case (sel)
            4'd0:    logic_out = ~chan_bad[0];
            4'd1:    logic_out = ~chan_bad[1];
            4'd2:    logic_out = ~chan_bad[2];
            4'd3:    logic_out = ~reg_oc_q;
            4'd4:    logic_out = ~(|uv_q);
            4'd5:    logic_out = ~(|ov_q);
            4'd6:    logic_out = ~mot_q;
            4'd7:    logic_out = ~tsd_q;
            4'd8:    logic_out = REV_CODE[0];
            4'd9:    logic_out = REV_CODE[1];
            4'd10:   logic_out = REV_CODE[2];
            4'd11:   logic_out = DEV_CODE[0];
            4'd12:   logic_out = DEV_CODE[1];
            4'd13:   logic_out = 1'b1;
            4'd14:   logic_out = ~reg_any_q;
            4'd15:   logic_out = 1'b1;
            default: logic_out = 1'b1;
        endcase
    end

endmodule

// File: rtl/prot_supervisor.sv
module prot_supervisor
    import prot_sup_pkg::*;
#(
    parameter int         PULSE_LEN = 8,
    parameter logic [2:0] REV_CODE  = 3'b010,
    parameter logic [1:0] DEV_CODE  = 2'b01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_rst_n,
    input  logic       supply_low,
    input  logic       sleep_n,
    input  logic [2:0] conv_uv,
    input  logic [2:0] conv_ov,
    input  logic [2:0] conv_oc,
    input  logic       reg_oc,
    input  logic       reg_fault,
    input  logic       motor_oc,
    input  logic       thermal,
    input  logic [1:0] tsd_mode,
    input  logic       misd_mode,
    input  logic [3:0] sel,
    output logic       conv_on,
    output logic       reg_on,
    output logic       motor_on,
    output logic       rst_out_n,
    output logic       logic_out
);

    logic [NUM_CONV-1:0] uv_q, ov_q, oc_q;
    logic                reg_oc_q, reg_any_q, mot_q, tsd_q;
    fault_summary_t      summ;
    sv_state_e           state_q, state_d;
    logic                pulse_run, pulse_done;

    fault_latch_bank u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_rst_n  (ext_rst_n),
        .supply_low (supply_low),
        .sleep_n    (sleep_n),
        .conv_uv    (conv_uv),
        .conv_ov    (conv_ov),
        .conv_oc    (conv_oc),
        .reg_oc     (reg_oc),
        .reg_fault  (reg_fault),
        .motor_oc   (motor_oc),
        .thermal    (thermal),
        .tsd_mode   (tsd_mode),
        .misd_mode  (misd_mode),
        .uv_q       (uv_q),
        .ov_q       (ov_q),
        .oc_q       (oc_q),
        .reg_oc_q   (reg_oc_q),
        .reg_any_q  (reg_any_q),
        .mot_q      (mot_q),
        .tsd_q      (tsd_q),
        .summ       (summ)
    );

    assign pulse_run = (state_q == SV_SOFT_PULSE);

    rst_pulse_timer #(.PULSE_LEN(PULSE_LEN)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (pulse_run),
        .done  (pulse_done)
    );

    status_select #(.REV_CODE(REV_CODE), .DEV_CODE(DEV_CODE)) u_sel (
        .sel       (sel),
        .uv_q      (uv_q),
        .ov_q      (ov_q),
        .oc_q      (oc_q),
        .reg_oc_q  (reg_oc_q),
        .reg_any_q (reg_any_q),
        .mot_q     (mot_q),
        .tsd_q     (tsd_q),
        .logic_out (logic_out)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SV_RUN;
        else        state_q <= state_d;
    end

    // transitions, in priority order
    always_comb begin
        state_d = state_q;
        if (summ.conv_any) begin
            state_d = SV_CONV_OFF;
        end else if (summ.hard_any) begin
            state_d = SV_HARD_OFF;
        end else if (summ.soft_any) begin
            unique case (state_q)
                SV_SOFT_PULSE: state_d = pulse_done ? SV_SOFT_HOLD : SV_SOFT_PULSE;
                SV_SOFT_HOLD:  state_d = SV_SOFT_HOLD;
                default:       state_d = summ.pulse_want ? SV_SOFT_PULSE : SV_SOFT_HOLD;
            endcase
        end else begin
            state_d = SV_RUN;
        end
    end

    // outputs decoded from the state alone
    always_comb begin
        conv_on   = 1'b1;
        reg_on    = 1'b1;
        motor_on  = 1'b1;
        rst_out_n = 1'b1;
        unique case (state_q)
            SV_RUN: begin
            end
            SV_CONV_OFF: begin
                conv_on   = 1'b0;
                motor_on  = 1'b0;
                rst_out_n = 1'b0;
            end
            SV_HARD_OFF: begin
                conv_on   = 1'b0;
                reg_on    = 1'b0;
                motor_on  = 1'b0;
                rst_out_n = 1'b0;
            end
            SV_SOFT_PULSE: begin
                motor_on  = 1'b0;
                rst_out_n = 1'b0;
            end
            SV_SOFT_HOLD: begin
                motor_on  = 1'b0;
            end
            default: begin
                conv_on   = 1'b0;
                reg_on    = 1'b0;
                motor_on  = 1'b0;
                rst_out_n = 1'b0;
            end
        endcase
    end

    // R1 / R9: a converter fault wins and shuts converters and motors
    assert_conv_shut_R1: assert property (@(posedge clk) disable iff (!rst_n)
        summ.conv_any |=> !conv_on && !motor_on && reg_on && !rst_out_n)
        else $error("converter fault reaction wrong");

    // R2 / R6: hard-mode fault turns everything off
    assert_hard_shut_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (summ.hard_any && !summ.conv_any) |=> !conv_on && !reg_on && !motor_on && !rst_out_n)
        else $error("hard fault reaction wrong");

    // R3 / R5: soft-mode fault stops motors only
    assert_soft_motors_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (summ.soft_any && !summ.hard_any && !summ.conv_any) |=> conv_on && reg_on && !motor_on)
        else $error("soft fault reaction wrong");

    // R7: no latched fault means run values next cycle
    assert_run_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!summ.conv_any && !summ.hard_any && !summ.soft_any) |=> motor_on && rst_out_n && conv_on)
        else $error("clean state not in run");

    // R11: code 1111 is a constant high
    assert_fixed_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 4'b1111) |-> logic_out)
        else $error("fixed-high select not high");

endmodule

// File: tb/prot_supervisor_test.sv
module prot_supervisor_test;

    localparam int         PLEN = 6;
    localparam logic [2:0] REV  = 3'b101;
    localparam logic [1:0] DEV  = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       supply_low = 1'b0;
    logic       sleep_n = 1'b1;
    logic [2:0] conv_uv = '0, conv_ov = '0, conv_oc = '0;
    logic       reg_oc = 1'b0, reg_fault = 1'b0, motor_oc = 1'b0, thermal = 1'b0;
    logic [1:0] tsd_mode = 2'b00;
    logic       misd_mode = 1'b0;
    logic [3:0] sel = 4'd15;
    logic       conv_on, reg_on, motor_on, rst_out_n, logic_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string phase = "R8 reset state";

    always #10 clk = ~clk;

    prot_supervisor #(.PULSE_LEN(PLEN), .REV_CODE(REV), .DEV_CODE(DEV)) uut (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .supply_low(supply_low),
        .sleep_n(sleep_n), .conv_uv(conv_uv), .conv_ov(conv_ov), .conv_oc(conv_oc),
        .reg_oc(reg_oc), .reg_fault(reg_fault), .motor_oc(motor_oc), .thermal(thermal),
        .tsd_mode(tsd_mode), .misd_mode(misd_mode), .sel(sel),
        .conv_on(conv_on), .reg_on(reg_on), .motor_on(motor_on),
        .rst_out_n(rst_out_n), .logic_out(logic_out)
    );

    // behavioural reference
    logic [2:0] m_uv = '0, m_ov = '0, m_oc = '0;
    bit m_roc, m_rany, m_mot, m_mot_hard, m_tsd, m_tsd_hard, m_tsd_pulse;
    bit m_sleep_q = 1'b1;
    int m_mode = 0;   // 0 run, 1 conv off, 2 hard off, 3 pulsing, 4 holding
    int m_cnt = 0;
    int m_next;
    bit m_conv, m_hard, m_soft, m_pw, m_hc, m_sc;
    bit e_lo;
    logic [4:0] exp_v, act_v;

    function automatic bit lo_expect(input logic [3:0] s);
        logic [2:0] bad;
        bad = m_uv | m_ov | m_oc;
        case (s)
            4'd0, 4'd1, 4'd2: return !bad[s];
            4'd3:  return !m_roc;
            4'd4:  return m_uv == 3'b000;
            4'd5:  return m_ov == 3'b000;
            4'd6:  return !m_mot;
            4'd7:  return !m_tsd;
            4'd8, 4'd9, 4'd10: return REV[s - 4'd8];
            4'd11, 4'd12: return DEV[s - 4'd11];
            4'd14: return !m_rany;
            default: return 1'b1;
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_uv = '0; m_ov = '0; m_oc = '0; m_roc = 0; m_rany = 0;
            m_mot = 0; m_mot_hard = 0; m_tsd = 0; m_tsd_hard = 0; m_tsd_pulse = 0;
            m_sleep_q = 1; m_mode = 0; m_cnt = 0;
        end else begin
            m_conv = (m_uv | m_ov | m_oc) != 3'b000;
            m_hard = (m_mot && m_mot_hard) || (m_tsd && m_tsd_hard);
            m_soft = (m_mot && !m_mot_hard) || (m_tsd && !m_tsd_hard);
            m_pw   = (m_mot && !m_mot_hard) || (m_tsd && m_tsd_pulse);
            if (m_conv) m_next = 1;
            else if (m_hard) m_next = 2;
            else if (m_soft) begin
                if (m_mode == 3) m_next = (m_cnt == PLEN - 1) ? 4 : 3;
                else if (m_mode == 4) m_next = 4;
                else m_next = m_pw ? 3 : 4;
            end else m_next = 0;
            m_cnt  = (m_mode == 3) ? m_cnt + 1 : 0;
            m_mode = m_next;
            m_hc = supply_low || !ext_rst_n;
            m_sc = sleep_n && !m_sleep_q;
            m_sleep_q = sleep_n;
            if (m_hc) begin
                m_uv = '0; m_ov = '0; m_oc = '0; m_roc = 0; m_rany = 0;
                m_mot = 0; m_mot_hard = 0; m_tsd = 0; m_tsd_hard = 0; m_tsd_pulse = 0;
            end else begin
                m_uv |= conv_uv; m_ov |= conv_ov; m_oc |= conv_oc;
                m_roc |= reg_oc; m_rany |= reg_fault;
                if (m_mot && m_sc && !m_mot_hard) m_mot = 0;
                else if (!m_mot && motor_oc) begin m_mot = 1; m_mot_hard = misd_mode; end
                if (m_tsd && m_sc && !m_tsd_hard) m_tsd = 0;
                else if (!m_tsd && thermal) begin
                    m_tsd = 1;
                    m_tsd_hard = (tsd_mode == 2'b00) || (tsd_mode == 2'b11);
                    m_tsd_pulse = (tsd_mode == 2'b10);
                end
            end
        end
        #5;
        e_lo = lo_expect(sel);
        exp_v = {m_mode != 1 && m_mode != 2, m_mode != 2, m_mode == 0,
                 m_mode == 0 || m_mode == 4, e_lo};
        act_v = {conv_on, reg_on, motor_on, rst_out_n, logic_out};
        checks++;
        if (act_v !== exp_v) begin
            failures++;
            $display("FAIL %s cycle %0d: {conv,reg,motor,rst,lo} actual=%b expected=%b",
                     phase, cycles, act_v, exp_v);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {conv,reg,motor,rst} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic chk_lo(input logic [3:0] s, input logic exp, input string tag);
        sel = s;
        @(posedge clk); #2;
        checks++;
        if (logic_out !== exp) begin
            failures++;
            $display("FAIL %s sel=%0d: actual=%b expected=%b", tag, s, logic_out, exp);
        end
        @(negedge clk);
    endtask

    task automatic sleep_rise();
        sleep_n = 1'b0; cyc(1); sleep_n = 1'b1; cyc(1);
    endtask

    task automatic hard_rel(input bit use_supply);
        if (use_supply) supply_low = 1'b1; else ext_rst_n = 1'b0;
        cyc(1);
        supply_low = 1'b0; ext_rst_n = 1'b1;
        cyc(1);
    endtask

    function automatic logic [3:0] outs();
        return {conv_on, reg_on, motor_on, rst_out_n};
    endfunction

    initial begin
        int lows;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk(outs(), 4'b1111, "R8 reset state");

        // R1: converter B under-voltage, one-cycle flag
        phase = "R1 converter fault";
        conv_uv = 3'b010; cyc(1); conv_uv = '0; cyc(1);
        chk(outs(), 4'b0100, "R1 converter shutdown");
        sleep_rise(); cyc(2);
        chk(outs(), 4'b0100, "R1 sleep edge ignored");
        phase = "R7 supply-low release";
        hard_rel(1'b1);
        chk(outs(), 4'b1111, "R7 release by supply low");
        conv_oc = 3'b100; cyc(1); conv_oc = '0; cyc(3);
        hard_rel(1'b0);
        chk(outs(), 4'b1111, "R7 release by reset input");

        // R2: thermal mode 00 and 11
        for (int k = 0; k < 2; k++) begin
            phase = "R2 thermal hard";
            tsd_mode = (k == 0) ? 2'b00 : 2'b11;
            thermal = 1'b1; cyc(1); thermal = 1'b0; cyc(1);
            chk(outs(), 4'b0000, "R2 thermal hard off");
            sleep_rise(); cyc(1);
            chk(outs(), 4'b0000, "R2 sleep edge ignored");
            hard_rel(k == 0);
        end

        // R3: thermal mode 01
        phase = "R3 thermal soft";
        tsd_mode = 2'b01;
        thermal = 1'b1; cyc(1); thermal = 1'b0; cyc(1);
        chk(outs(), 4'b1101, "R3 motors off, reset-out high");
        sleep_rise(); cyc(1);
        chk(outs(), 4'b1111, "R3 sleep edge clears");

        // R4: thermal mode 10, count reset-out low cycles
        phase = "R4 thermal pulse";
        tsd_mode = 2'b10;
        thermal = 1'b1; cyc(1); thermal = 1'b0;
        lows = 0;
        for (int i = 0; i < 4 * PLEN; i++) begin
            cyc(1);
            if (!rst_out_n) lows++;
        end
        checks++;
        if (lows != PLEN) begin
            failures++;
            $display("FAIL R4 pulse width: actual=%0d expected=%0d", lows, PLEN);
        end
        chk(outs(), 4'b1101, "R4 after pulse");
        sleep_rise(); cyc(1);

        // R5: motor soft with pulse
        phase = "R5 motor soft";
        misd_mode = 1'b0;
        motor_oc = 1'b1; cyc(1); motor_oc = 1'b0; cyc(1);
        chk(outs(), 4'b1100, "R5 motors off, reset-out pulsing");
        cyc(PLEN + 2);
        chk(outs(), 4'b1101, "R5 pulse finished");
        sleep_rise(); cyc(1);
        chk(outs(), 4'b1111, "R5 sleep edge clears");

        // R6: motor hard
        phase = "R6 motor hard";
        misd_mode = 1'b1;
        motor_oc = 1'b1; cyc(1); motor_oc = 1'b0; cyc(1);
        chk(outs(), 4'b0000, "R6 all off");
        sleep_rise(); cyc(1);
        chk(outs(), 4'b0000, "R6 sleep edge ignored");
        hard_rel(1'b0);

        // R8: mode captured at latch time
        phase = "R8 mode capture";
        tsd_mode = 2'b01;
        thermal = 1'b1; cyc(1); thermal = 1'b0; tsd_mode = 2'b00; cyc(2);
        chk(outs(), 4'b1101, "R8 later mode change ignored");
        sleep_rise(); cyc(1);
        chk(outs(), 4'b1111, "R8 soft clear still applies");

        // R9: priority
        phase = "R9 priority";
        tsd_mode = 2'b01;
        thermal = 1'b1; cyc(1); thermal = 1'b0; cyc(2);
        misd_mode = 1'b1; motor_oc = 1'b1; cyc(1); motor_oc = 1'b0; cyc(1);
        chk(outs(), 4'b0000, "R9 hard over soft");
        conv_ov = 3'b001; cyc(1); conv_ov = '0; cyc(1);
        chk(outs(), 4'b0100, "R9 converter over hard");
        hard_rel(1'b1);

        // R10 / R11: logic-out routing
        phase = "R10 logic-out faults";
        conv_uv = 3'b010; reg_fault = 1'b1; cyc(1); conv_uv = '0; reg_fault = 1'b0;
        chk_lo(4'd0, 1'b1, "R10 channel A clear");
        chk_lo(4'd1, 1'b0, "R10 channel B fault");
        chk_lo(4'd4, 1'b0, "R10 under-voltage");
        chk_lo(4'd5, 1'b1, "R10 over-voltage clear");
        chk_lo(4'd14, 1'b0, "R10 regulator fault");
        phase = "R11 logic-out constants";
        for (int s = 8; s < 16; s++) begin
            logic e;
            if (s <= 10) e = REV[s - 8];
            else if (s <= 12) e = DEV[s - 11];
            else if (s == 14) e = 1'b0;
            else e = 1'b1;
            chk_lo(4'(s), e, "R11 constant code");
        end
        hard_rel(1'b0);
        phase = "R10 sweep clean";
        for (int s = 0; s < 16; s++) begin sel = 4'(s); cyc(1); end

        phase = "end";
        cyc(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #3000000;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule